// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a two-way set-associative data cache placed between a processor request port and a memory port that moves one whole line per transfer. Each processor request carries a byte address, a read/write flag, one data word and per-byte enables. The block splits the address into tag, set index and byte offset. It reads both ways of the indexed set at once and, on a hit, answers in the next cycle with no memory traffic.

A miss stalls the request port and runs a small sequencer. It chooses the less recently used way of the set. If that way holds a modified line, the line is first sent back to memory. The wanted line is then fetched, installed, merged with the store data when the request was a write, and the response is returned. Stores that hit only change the cached copy and mark it modified. Memory catches up when that line is evicted. Only one miss is handled at a time.

Top module: `cache_2way`

## Requirements
- R1: After reset the request port is ready, no response is pending, no memory transfer is requested, and every line is invalid, so the first access to any address misses.
- R2: With the default sizes, address bits [3:0] are the byte offset (bits [3:2] pick one of four 32-bit words), bits [5:4] are the set index and bits [15:6] are the tag. Addresses that differ only in tag compete for the same two ways. Addresses in different sets never evict one another.
- R3: A read that hits drives rsp_valid in the cycle after acceptance, with the addressed word. No memory transfer takes place.
- R4: A read miss fetches the whole line from the line-aligned address (offset bits zero). The response carries the requested word of that line.
- R5: A write that hits changes only the enabled bytes of the cached word and marks the line modified. It starts no memory transfer.
- R6: A write miss fetches the line from memory first, then merges the enabled bytes into it. The line is then marked modified.
- R7: On a miss with both ways valid, the victim is the way that was not touched by the most recent read hit, write hit or fill in that set.
- R8: A modified victim is written to memory as one whole line at its own line address, before the refill request. A clean or invalid victim causes no memory write.
- R9: req_ready stays low from the cycle after a miss is accepted until the cycle in which its response appears. No response appears while a memory transfer is requested.
- R10: The response to a write returns the stored word after the byte merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Byte enables, bit i covers bits [8i+7:8i] |
| rsp_valid | output | 1 | One-cycle pulse, request completed |
| rsp_rdata | output | 32 | Loaded word, or the merged word for a store |
| mem_req_valid | output | 1 | Memory transfer requested, held until mem_ack |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_req_addr | output | 16 | Line-aligned byte address |
| mem_wline | output | 128 | Line data for a write-back |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rline | input | 128 | Fetched line, valid with mem_ack |

## Verification
A corrupted tag, valid bit or LRU bit shows up at the ports in one of two ways. An access that should hit produces memory traffic instead of a response in the next cycle. Or an eviction sends back the wrong line or skips it. A lost dirty bit stays hidden until that line is evicted, and only then does a missing or stale write-back appear on the memory port. For that reason the bench forces conflict evictions soon after stores. It also compares every line sent to memory against a flat byte-level image of all writes.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_FETCH   = 2'd2,
    ST_ANSWER  = 2'd3
  } miss_state_e;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
  parameter int unsigned TAG_W  = 10,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned LINE_W = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SET_W-1:0]        rd_set,
  output logic [1:0][TAG_W-1:0]   rd_tag,
  output logic [1:0]              rd_valid,
  output logic [1:0]              rd_dirty,
  output logic [1:0][LINE_W-1:0]  rd_line,
  input  logic                    wr_en,
  input  logic [SET_W-1:0]        wr_set,
  input  logic                    wr_way,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic                    wr_dirty,
  input  logic [LINE_W-1:0]       wr_line,
  input  logic                    lru_we,
  input  logic [SET_W-1:0]        lru_set,
  input  logic                    lru_val,
  output logic [(1<<SET_W)-1:0]   lru_bits
);
  localparam int unsigned SETS = 1 << SET_W;

  for (genvar w = 0; w < cache_pkg::NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   dty_q;
    logic              sel_w;

    assign sel_w = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
        for (int s = 0; s < SETS; s++) begin
          tag_q[s]  <= '0;
          line_q[s] <= '0;
        end
      end else if (sel_w) begin
        vld_q[wr_set]  <= 1'b1;
        dty_q[wr_set]  <= wr_dirty;
        tag_q[wr_set]  <= wr_tag;
        line_q[wr_set] <= wr_line;
      end
    end

    assign rd_tag[w]   = tag_q[rd_set];
    assign rd_line[w]  = line_q[rd_set];
    assign rd_valid[w] = vld_q[rd_set];
    assign rd_dirty[w] = dty_q[rd_set];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru_bits <= '0;
    end else if (lru_we) begin
      lru_bits[lru_set] <= lru_val;
    end
  end
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int unsigned TAG_W  = 10,
  parameter int unsigned LINE_W = 128,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WSEL_W = 2
) (
  input  logic [TAG_W-1:0]        addr_tag,
  input  logic [WSEL_W-1:0]       word_sel,
  input  logic [1:0][TAG_W-1:0]   way_tag,
  input  logic [1:0]              way_valid,
  input  logic [1:0][LINE_W-1:0]  way_line,
  output logic [1:0]              way_hit,
  output logic                    hit,
  output logic                    hit_way,
  output logic [LINE_W-1:0]       hit_line,
  output logic [WORD_W-1:0]       hit_word
);
  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WSEL_W-1:0] sel);
    return ln[sel*WORD_W +: WORD_W];
  endfunction

  for (genvar w = 0; w < cache_pkg::NUM_WAYS; w++) begin : g_cmp
    assign way_hit[w] = way_valid[w] && (way_tag[w] == addr_tag);
  end

  assign hit      = |way_hit;
  assign hit_way  = way_hit[1];
  assign hit_line = way_hit[1] ? way_line[1] : way_line[0];
  assign hit_word = pick_word(hit_line, word_sel);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [WORD_W-1:0]            req_wdata,
  input  logic [WORD_W/8-1:0]          req_be,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_rdata,
  output logic                         mem_req_valid,
  output logic                         mem_req_write,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [(8<<OFF_W)-1:0]        mem_wline,
  input  logic                         mem_ack,
  input  logic [(8<<OFF_W)-1:0]        mem_rline,
  output logic [SET_W-1:0]             look_set,
  output logic [ADDR_W-OFF_W-SET_W-1:0] look_tag,
  output logic [$clog2((8<<OFF_W)/WORD_W)-1:0] look_wsel,
  input  logic                         hit,
  input  logic                         hit_way,
  input  logic [(8<<OFF_W)-1:0]        hit_line,
  input  logic [WORD_W-1:0]            hit_word,
  input  logic [1:0][ADDR_W-OFF_W-SET_W-1:0] rd_tag,
  input  logic [1:0]                   rd_valid,
  input  logic [1:0]                   rd_dirty,
  input  logic [1:0][(8<<OFF_W)-1:0]   rd_line,
  input  logic [(1<<SET_W)-1:0]        lru_bits,
  output logic                         wr_en,
  output logic                         wr_way,
  output logic                         wr_dirty,
  output logic [(8<<OFF_W)-1:0]        wr_line,
  output logic                         lru_we,
  output logic                         lru_val,
  output logic                         hit_evt,
  output logic                         fill_evt,
  output logic                         fill_way
);
  localparam int unsigned LINE_W = 8 << OFF_W;
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_W);
  localparam int unsigned BOFF_W = $clog2(BE_W);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - SET_W;

  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] merge_line(input logic [LINE_W-1:0] ln,
                                                   input logic [WSEL_W-1:0] sel,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [BE_W-1:0]   be);
    logic [LINE_W-1:0] r;
    r = ln;
    r[sel*WORD_W +: WORD_W] = merge_word(ln[sel*WORD_W +: WORD_W], new_w, be);
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  miss_state_e       state_q;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_write;
  logic [WORD_W-1:0] lat_wdata;
  logic [BE_W-1:0]   lat_be;
  logic              vic_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              accept;
  logic              miss_evt;
  logic              vic_now;

  assign cur_addr  = (state_q == ST_IDLE) ? req_addr : lat_addr;
  assign look_set  = cur_addr[OFF_W +: SET_W];
  assign look_tag  = cur_addr[ADDR_W-1 -: TAG_W];
  assign look_wsel = cur_addr[OFF_W-1 : BOFF_W];

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_evt   = accept && hit;
  assign miss_evt  = accept && !hit;
  assign vic_now   = lru_bits[look_set];
  assign fill_evt  = (state_q == ST_FETCH) && mem_ack;
  assign fill_way  = vic_q;

  always_comb begin
    wr_en    = 1'b0;
    wr_way   = 1'b0;
    wr_dirty = 1'b0;
    wr_line  = hit_line;
    if (hit_evt && req_write) begin
      wr_en    = 1'b1;
      wr_way   = hit_way;
      wr_dirty = 1'b1;
      wr_line  = merge_line(hit_line, look_wsel, req_wdata, req_be);
    end else if (fill_evt) begin
      wr_en    = 1'b1;
      wr_way   = vic_q;
      wr_dirty = lat_write;
      wr_line  = lat_write ? merge_line(mem_rline, look_wsel, lat_wdata, lat_be)
                           : mem_rline;
    end
  end

  assign lru_we  = hit_evt || fill_evt;
  assign lru_val = hit_evt ? ~hit_way : ~vic_q;

  assign mem_req_valid = (state_q == ST_FLUSH) || (state_q == ST_FETCH);
  assign mem_req_write = (state_q == ST_FLUSH);
  assign mem_req_addr  = (state_q == ST_FLUSH) ? line_base(rd_tag[vic_q], look_set)
                                               : line_base(look_tag, look_set);
  assign mem_wline     = rd_line[vic_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
      lat_be    <= '0;
      vic_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (miss_evt) begin
            lat_addr  <= req_addr;
            lat_write <= req_write;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
            vic_q     <= vic_now;
            state_q   <= (rd_valid[vic_now] && rd_dirty[vic_now]) ? ST_FLUSH : ST_FETCH;
          end
        end
        ST_FLUSH:  if (mem_ack) state_q <= ST_FETCH;
        ST_FETCH:  if (mem_ack) state_q <= ST_ANSWER;
        ST_ANSWER: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (hit_evt) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= req_write ? merge_word(hit_word, req_wdata, req_be) : hit_word;
      end else if (state_q == ST_ANSWER) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= hit_word;
      end
    end
  end
endmodule

// File: rtl/cache_2way.sv
module cache_2way #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  input  logic [WORD_W/8-1:0]      req_be,
  output logic                     rsp_valid,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic                     mem_req_valid,
  output logic                     mem_req_write,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [(8<<OFF_W)-1:0]    mem_wline,
  input  logic                     mem_ack,
  input  logic [(8<<OFF_W)-1:0]    mem_rline
);
  localparam int unsigned LINE_W = 8 << OFF_W;
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_W);

  logic [SET_W-1:0]          look_set;
  logic [TAG_W-1:0]          look_tag;
  logic [WSEL_W-1:0]         look_wsel;
  logic [1:0][TAG_W-1:0]     rd_tag;
  logic [1:0]                rd_valid;
  logic [1:0]                rd_dirty;
  logic [1:0][LINE_W-1:0]    rd_line;
  logic [(1<<SET_W)-1:0]     lru_bits;
  logic [1:0]                way_hit;
  logic                      hit;
  logic                      hit_way;
  logic [LINE_W-1:0]         hit_line;
  logic [WORD_W-1:0]         hit_word;
  logic                      wr_en;
  logic                      wr_way;
  logic                      wr_dirty;
  logic [LINE_W-1:0]         wr_line;
  logic                      lru_we;
  logic                      lru_val;
  logic                      hit_evt;
  logic                      fill_evt;
  logic                      fill_way;

  cache_store #(.TAG_W(TAG_W), .SET_W(SET_W), .LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (look_set),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_line  (rd_line),
    .wr_en    (wr_en),
    .wr_set   (look_set),
    .wr_way   (wr_way),
    .wr_tag   (look_tag),
    .wr_dirty (wr_dirty),
    .wr_line  (wr_line),
    .lru_we   (lru_we),
    .lru_set  (look_set),
    .lru_val  (lru_val),
    .lru_bits (lru_bits)
  );

  cache_lookup #(.TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) u_look (
    .addr_tag  (look_tag),
    .word_sel  (look_wsel),
    .way_tag   (rd_tag),
    .way_valid (rd_valid),
    .way_line  (rd_line),
    .way_hit   (way_hit),
    .hit       (hit),
    .hit_way   (hit_way),
    .hit_line  (hit_line),
    .hit_word  (hit_word)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WORD_W(WORD_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_be        (req_be),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_wline     (mem_wline),
    .mem_ack       (mem_ack),
    .mem_rline     (mem_rline),
    .look_set      (look_set),
    .look_tag      (look_tag),
    .look_wsel     (look_wsel),
    .hit           (hit),
    .hit_way       (hit_way),
    .hit_line      (hit_line),
    .hit_word      (hit_word),
    .rd_tag        (rd_tag),
    .rd_valid      (rd_valid),
    .rd_dirty      (rd_dirty),
    .rd_line       (rd_line),
    .lru_bits      (lru_bits),
    .wr_en         (wr_en),
    .wr_way        (wr_way),
    .wr_dirty      (wr_dirty),
    .wr_line       (wr_line),
    .lru_we        (lru_we),
    .lru_val       (lru_val),
    .hit_evt       (hit_evt),
    .fill_evt      (fill_evt),
    .fill_way      (fill_way)
  );
endmodule

// File: rtl/cache_2way_chk.sv
module cache_2way_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SET_W  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   mem_req_valid,
  input logic                   mem_req_write,
  input logic [ADDR_W-1:0]      mem_req_addr,
  input logic                   mem_ack,
  input logic                   hit_evt,
  input logic                   hit_way,
  input logic [1:0]             way_hit,
  input logic [SET_W-1:0]       look_set,
  input logic [(1<<SET_W)-1:0]  lru_bits,
  input logic                   fill_evt,
  input logic                   fill_way
);
  p_one_way_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  p_hit_next_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> rsp_valid);

  p_lru_after_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (lru_bits[$past(look_set)] != $past(hit_way)));

  p_lru_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (lru_bits[$past(look_set)] != $past(fill_way)));

  p_flush_then_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_ack) |=> (mem_req_valid && !mem_req_write));

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  p_stall_in_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (!req_ready && !rsp_valid));
endmodule

bind cache_2way cache_2way_chk #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_ack       (mem_ack),
  .hit_evt       (hit_evt),
  .hit_way       (hit_way),
  .way_hit       (way_hit),
  .look_set      (look_set),
  .lru_bits      (lru_bits),
  .fill_evt      (fill_evt),
  .fill_way      (fill_way)
);

// File: tb/sim_cache_2way.sv
`timescale 1ns/1ps
module sim_cache_2way;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic         req_write;
  logic [15:0]  req_addr;
  logic [31:0]  req_wdata;
  logic [3:0]   req_be;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid;
  logic         mem_req_write;
  logic [15:0]  mem_req_addr;
  logic [127:0] mem_wline;
  logic         mem_ack;
  logic [127:0] mem_rline;

  always #2 clk = ~clk;

  cache_2way u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_wline(mem_wline),
    .mem_ack(mem_ack), .mem_rline(mem_rline)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // backing store seen by the cache, and the flat image of every store made
  logic [127:0] mem_lines [int];
  logic [7:0]   gold [int];

  // traffic log for the current request
  int           wb_cnt, rf_cnt, wb_addr, rf_addr;
  logic [127:0] wb_data;

  // reference: per set a recency list, front is most recent
  typedef struct { int tag; bit dirty; } ent_t;
  ent_t model [4][$];

  function automatic logic [7:0] seed_byte(int a);
    return 8'((a * 37) + ((a >> 8) * 11) + 60);
  endfunction

  function automatic logic [127:0] backing_line(int la);
    logic [127:0] l;
    if (mem_lines.exists(la)) return mem_lines[la];
    for (int i = 0; i < 16; i++) l[8*i +: 8] = seed_byte(la + i);
    return l;
  endfunction

  function automatic logic [7:0] gold_byte(int a);
    return gold.exists(a) ? gold[a] : seed_byte(a);
  endfunction

  function automatic logic [127:0] gold_line(int la);
    logic [127:0] l;
    for (int i = 0; i < 16; i++) l[8*i +: 8] = gold_byte(la + i);
    return l;
  endfunction

  function automatic logic [31:0] gold_word(int a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = gold_byte((a & ~3) + i);
    return w;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory responder: acks two cycles after a request is seen
  initial begin
    int wcnt;
    wcnt = 0;
    mem_ack = 1'b0;
    mem_rline = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req_valid) begin
        wcnt++;
        if (wcnt >= 2) begin
          int la;
          wcnt = 0;
          la = int'(mem_req_addr);
          if (mem_req_write) begin
            mem_lines[la] = mem_wline;
            wb_cnt++;
            wb_addr = la;
            wb_data = mem_wline;
          end else begin
            mem_rline = backing_line(la);
            rf_cnt++;
            rf_addr = la;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic access(bit wr, int addr, logic [31:0] wd, logic [3:0] be, string hm_rq = "R7");
    int tag, set, la, cycles;
    bit exp_hit, exp_wb, ready_bad;
    int exp_wb_addr;
    logic [127:0] exp_wb_data;
    logic [31:0] exp_word;
    int idx;
    tag = addr >> 6; set = (addr >> 4) & 3; la = addr & ~15;
    idx = -1;
    foreach (model[set][i]) if (model[set][i].tag == tag) idx = i;
    exp_hit = (idx >= 0);
    exp_wb = 0; exp_wb_addr = 0; exp_wb_data = '0;
    if (exp_hit) begin
      ent_t e;
      e = model[set][idx];
      model[set].delete(idx);
      if (wr) e.dirty = 1;
      model[set].push_front(e);
    end else begin
      ent_t e;
      if (model[set].size() == 2) begin
        ent_t v;
        v = model[set].pop_back();
        exp_wb = v.dirty;
        exp_wb_addr = (v.tag << 6) | (set << 4);
        exp_wb_data = gold_line(exp_wb_addr);
      end
      e.tag = tag; e.dirty = wr;
      model[set].push_front(e);
    end
    if (wr) begin
      for (int b = 0; b < 4; b++) if (be[b]) gold[(addr & ~3) + b] = wd[8*b +: 8];
    end
    exp_word = gold_word(addr);

    wb_cnt = 0; rf_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 16'(addr); req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 1; ready_bad = 0;
    while (!rsp_valid && cycles < 200) begin
      if (req_ready) ready_bad = 1;
      @(negedge clk);
      cycles++;
    end
    chk(rsp_valid == 1'b1, "R9", "response arrives", 128'(rsp_valid), 128'(1));
    chk(!ready_bad, "R9", "ready low during miss", 128'(ready_bad), 128'(0));
    chk(exp_hit == (cycles == 1 && rf_cnt == 0), hm_rq, "hit/miss", 128'(cycles), exp_hit ? 128'(1) : 128'(0));
    chk(rsp_rdata == exp_word, wr ? "R10" : (exp_hit ? "R3" : "R4"), "response word",
        128'(rsp_rdata), 128'(exp_word));
    if (exp_hit) begin
      chk(wb_cnt == 0 && rf_cnt == 0, wr ? "R5" : "R3", "no memory traffic on hit",
          128'(wb_cnt + rf_cnt), 128'(0));
    end else begin
      chk(rf_cnt == 1 && rf_addr == la, wr ? "R6" : "R4", "refill line address",
          128'(rf_addr), 128'(la));
      chk(wb_cnt == int'(exp_wb), "R8", "write-back count", 128'(wb_cnt), 128'(exp_wb));
      if (exp_wb && wb_cnt == 1) begin
        chk(wb_addr == exp_wb_addr, "R8", "write-back address", 128'(wb_addr), 128'(exp_wb_addr));
        chk(wb_data == exp_wb_data, "R8", "write-back line", wb_data, exp_wb_data);
      end
    end
  endtask

  function automatic int mk(int tag, int set, int off);
    return (tag << 6) | (set << 4) | off;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "idle after reset",
        128'({req_ready, rsp_valid, mem_req_valid}), 128'(3'b100));

    access(0, mk(1, 0, 0), '0, '0, "R1");                 // cold miss
    access(0, mk(1, 0, 4), '0, '0);                       // hit, other word
    access(1, mk(1, 0, 8), 32'hDEADBEEF, 4'b0101);        // write hit, partial
    access(0, mk(1, 0, 8), '0, '0);                       // read merged back
    access(0, mk(1, 1, 0), '0, '0, "R2");                 // same tag other set: miss
    access(0, mk(2, 0, 0), '0, '0, "R2");                 // same set, fills 2nd way
    access(0, mk(1, 0, 12), '0, '0, "R2");                // set 1 fill did not disturb set 0
    access(0, mk(3, 0, 0), '0, '0);                       // evicts tag 2, clean
    access(0, mk(1, 0, 0), '0, '0);                       // still resident
    access(0, mk(4, 0, 4), '0, '0);                       // evicts tag 3
    access(0, mk(5, 0, 0), '0, '0);                       // evicts dirty tag 1
    access(1, mk(6, 2, 4), 32'h01234567, 4'b1111);        // write miss allocate
    access(1, mk(6, 2, 12), 32'hCAFE0000, 4'b1100);       // write hit
    access(0, mk(7, 2, 0), '0, '0);
    access(0, mk(7, 2, 0), '0, '0);                       // tag 6 now least recent
    access(0, mk(8, 2, 0), '0, '0);                       // evicts dirty tag 6

    seed = 32'h1357;
    for (int n = 0; n < 400; n++) begin
      int t, s, o;
      bit w;
      seed = seed * 1103515245 + 12345;
      t = ((seed >> 16) & 3) + 1;
      s = (seed >> 20) % 3;
      o = ((seed >> 12) & 3) * 4;
      w = ((seed >> 24) & 1) == 1;
      access(w, mk(t, s, o), 32'(seed ^ n), 4'((seed >> 8) | 1));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule